// File: doc/BRIEF.md
# Montgomery Modular Exponentiator

This block raises a base to a power modulo an odd modulus. It drives two radix-2 Montgomery multipliers in lock step through a right-to-left square-and-multiply schedule. Every intermediate product stays in redundant carry-save form, as a pair of vectors, from one multiplication to the next. A carry-propagating addition happens only once, at the very end, and a single conditional subtraction then reduces the output fully.

One run has four parts. First, a pre-processing phase brings the base and the value one into the Montgomery domain. Next come one loop phase per exponent bit and a post-processing phase that leaves the domain. Last, a bit-serial addition phase resolves the final carry-save pair. Each phase lasts ITER+2 cycles, where ITER = N_W+2 is the number of Montgomery iterations per multiplication.

The caller must supply the domain-entry constant `rr_i` = 2^(2·ITER) mod n. The caller must also guarantee four operand conditions:
- n is odd;
- 1 < n < 2^N_W;
- the base is less than n;
- `explen_i` ≤ E_W.

A run starts with a one-cycle `start` pulse and ends with a one-cycle `valid_o` pulse.

Top module: `mexp_top`

## Requirements
- R1: When `valid_o` is high, `result_o` equals base^e mod n and is less than n. Here e is the exponent formed from the low `explen_i` bits of `exp_i`, as sampled at the accepting edge.
- R2: Exponent bits are consumed from bit 0 upward. Bits of `exp_i` at positions `explen_i` and above have no effect on the result.
- R3: An exponent length of 0, or an all-zero exponent, yields a result of 1.
- R4: A base of 0 with a nonzero effective exponent yields a result of 0.
- R5: `valid_o` rises exactly (N_W+4)·(`explen_i`+3) clock edges after the edge that accepts `start`, and it stays high for exactly one cycle.
- R6: A start is accepted on any edge where `start` is high and `busy_o` is low. `busy_o` is high from the accepting edge until the edge that raises `valid_o`, and it is low while `valid_o` is high.
- R7: While `busy_o` is high, `start` and all operand inputs are ignored. The result and the timing of the run in progress are unaffected.
- R8: After reset, `busy_o` and `valid_o` are 0 and `result_o` is 0. `result_o` holds its last value until the next `valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a run; sampled when not busy |
| base_i | input | N_W | Base, less than the modulus |
| mod_i | input | N_W | Odd modulus greater than 1 |
| rr_i | input | N_W | 2^(2·(N_W+2)) mod n, computed by the caller |
| exp_i | input | E_W | Exponent bits, bit 0 used first |
| explen_i | input | $clog2(E_W+1) | Number of exponent bits to use |
| busy_o | output | 1 | Run in progress |
| valid_o | output | 1 | One-cycle pulse: result_o is new |
| result_o | output | N_W | Fully reduced result |

## Verification
The hardest condition to reach is a start request that arrives while a run is in progress, carrying operands that differ from those already accepted. The stimulus issues such a request mid-run with a different modulus, base and length, and the per-cycle model must show no change in either the result or the completion cycle.

The other hard case is a set of exponent bits above the stated length, whose effect is invisible unless the length is deliberately shorter than the word. The stimulus sets those upper bits to ones and compares the result against the truncated exponent.

Random runs sweep the exponent length from 0 to E_W with random odd moduli, so that the conditional final subtraction is taken on some runs and skipped on others.

// File: rtl/mexp_pkg.sv
package mexp_pkg;
   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_MUL  = 2'd1,
      S_ADD  = 2'd2
   } mexp_state_t;
endpackage

// File: rtl/mexp_csa3.sv
module mexp_csa3 #(
   parameter int WE = 16
) (
   input  logic [WE-1:0] x_i,
   input  logic [WE-1:0] y_i,
   input  logic [WE-1:0] z_i,
   output logic [WE-1:0] s_o,
   output logic [WE-1:0] c_o
);
   logic [WE-2:0] maj;

   assign s_o = x_i ^ y_i ^ z_i;
   assign maj = (x_i[WE-2:0] & y_i[WE-2:0]) | (x_i[WE-2:0] & z_i[WE-2:0])
              | (y_i[WE-2:0] & z_i[WE-2:0]);
   assign c_o = {maj, 1'b0};
endmodule

// File: rtl/mexp_csmul.sv
module mexp_csmul #(
   parameter int W = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic         en,
   input  logic [W-1:0] a1_i,
   input  logic [W-1:0] a2_i,
   input  logic [W-1:0] b1_i,
   input  logic [W-1:0] b2_i,
   input  logic [W-1:0] n_i,
   output logic [W-1:0] s1_o,
   output logic [W-1:0] s2_o
);
   localparam int WE = W + 1;

   logic [W-1:0]  ax, ay, bx, by, nr, s1r, s2r;
   logic          ac, ai, ac_nxt, qb;
   logic [WE-1:0] t1, t2, tb1, tb2, tn;
   logic [WE-1:0] u_s, u_c, v_s, v_c, f_s, f_c;
   logic          unused_lsb;

   // serial recovery of the multiplier bit from the carry-save A pair
   assign ai     = ax[0] ^ ay[0] ^ ac;
   assign ac_nxt = (ax[0] & ay[0]) | (ax[0] & ac) | (ay[0] & ac);

   assign t1  = {1'b0, s1r};
   assign t2  = {1'b0, s2r};
   assign tb1 = ai ? {1'b0, bx} : '0;
   assign tb2 = ai ? {1'b0, by} : '0;

   mexp_csa3 #(.WE(WE)) u_lvl1 (.x_i(t1),  .y_i(t2),  .z_i(tb1), .s_o(u_s), .c_o(u_c));
   mexp_csa3 #(.WE(WE)) u_lvl2 (.x_i(u_s), .y_i(u_c), .z_i(tb2), .s_o(v_s), .c_o(v_c));

   // parity of S + ai*B decides whether the modulus is added
   assign qb = v_s[0];
   assign tn = qb ? {1'b0, nr} : '0;

   mexp_csa3 #(.WE(WE)) u_lvl3 (.x_i(v_s), .y_i(v_c), .z_i(tn),  .s_o(f_s), .c_o(f_c));

   assign unused_lsb = f_s[0] ^ f_c[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ax  <= '0;
         ay  <= '0;
         ac  <= 1'b0;
         bx  <= '0;
         by  <= '0;
         nr  <= '0;
         s1r <= '0;
         s2r <= '0;
      end else if (go) begin
         ax  <= a1_i;
         ay  <= a2_i;
         ac  <= 1'b0;
         bx  <= b1_i;
         by  <= b2_i;
         nr  <= n_i;
         s1r <= '0;
         s2r <= '0;
      end else if (en) begin
         s1r <= f_s[W:1];
         s2r <= f_c[W:1];
         ax  <= ax >> 1;
         ay  <= ay >> 1;
         ac  <= ac_nxt;
      end
   end

   assign s1_o = s1r;
   assign s2_o = s2r;
endmodule

// File: rtl/mexp_top.sv
module mexp_top
   import mexp_pkg::*;
#(
   parameter  int N_W  = 12,
   parameter  int E_W  = 8,
   localparam int DK_W = $clog2(E_W + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [N_W-1:0]  base_i,
   input  logic [N_W-1:0]  mod_i,
   input  logic [N_W-1:0]  rr_i,
   input  logic [E_W-1:0]  exp_i,
   input  logic [DK_W-1:0] explen_i,
   output logic            busy_o,
   output logic            valid_o,
   output logic [N_W-1:0]  result_o
);
   localparam int W    = N_W + 2;
   localparam int IT   = W;
   localparam int CW   = $clog2(IT + 2);
   localparam int PH_W = $clog2(E_W + 2);
   localparam logic [CW-1:0] CYC_LAST = CW'(IT + 1);
   localparam logic [CW-1:0] CYC_SUB  = CW'(IT);

   generate
      if (N_W < 3) begin : g_bad_nw
         $error("mexp_top: N_W must be at least 3");
      end
      if (E_W < 1) begin : g_bad_ew
         $error("mexp_top: E_W must be at least 1");
      end
   endgenerate

   mexp_state_t     st;
   logic [CW-1:0]   cyc;
   logic [PH_W-1:0] ph, ph_post;
   logic [DK_W-1:0] dkq;
   logic [E_W-1:0]  dsh;
   logic [N_W-1:0]  nq, kq, cq, res_q;
   logic [W-1:0]    p1, p2, r1, r2, acc;
   logic            cy, val_q;
   logic            is_pre, is_post, go, en;
   logic [W-1:0]    kx, cx, one_w, nx;
   logic [W-1:0]    sq_a1, sq_a2, sq_b1, sq_b2, sq_s1, sq_s2;
   logic [W-1:0]    ml_a1, ml_a2, ml_b1, ml_b2, ml_s1, ml_s2;
   logic            sb, cy_nxt;

   assign ph_post = PH_W'(dkq) + PH_W'(1);
   assign is_pre  = (ph == '0);
   assign is_post = (ph == ph_post);
   assign go      = (st == S_MUL) && (cyc == '0);
   assign en      = (st == S_MUL) && (cyc != '0) && (cyc != CYC_LAST);

   assign kx    = W'(kq);
   assign cx    = W'(cq);
   assign nx    = W'(nq);
   assign one_w = W'(1);

   // squaring path: K*C in pre-processing, P*P in the loop
   assign sq_a1 = is_pre ? kx : p1;
   assign sq_a2 = is_pre ? '0 : p2;
   assign sq_b1 = is_pre ? cx : p1;
   assign sq_b2 = is_pre ? '0 : p2;

   // accumulator path: K*1, then R*P (old P), then 1*R
   assign ml_a1 = is_pre ? kx : (is_post ? one_w : r1);
   assign ml_a2 = (is_pre || is_post) ? '0 : r2;
   assign ml_b1 = is_pre ? one_w : (is_post ? r1 : p1);
   assign ml_b2 = is_pre ? '0 : (is_post ? r2 : p2);

   mexp_csmul #(.W(W)) u_sq (
      .clk(clk), .rst_n(rst_n), .go(go), .en(en),
      .a1_i(sq_a1), .a2_i(sq_a2), .b1_i(sq_b1), .b2_i(sq_b2), .n_i(nx),
      .s1_o(sq_s1), .s2_o(sq_s2)
   );

   mexp_csmul #(.W(W)) u_ml (
      .clk(clk), .rst_n(rst_n), .go(go), .en(en),
      .a1_i(ml_a1), .a2_i(ml_a2), .b1_i(ml_b1), .b2_i(ml_b2), .n_i(nx),
      .s1_o(ml_s1), .s2_o(ml_s2)
   );

   assign sb     = r1[0] ^ r2[0] ^ cy;
   assign cy_nxt = (r1[0] & r2[0]) | (r1[0] & cy) | (r2[0] & cy);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= S_IDLE;
         cyc   <= '0;
         ph    <= '0;
         dkq   <= '0;
         dsh   <= '0;
         nq    <= '0;
         kq    <= '0;
         cq    <= '0;
         p1    <= '0;
         p2    <= '0;
         r1    <= '0;
         r2    <= '0;
         acc   <= '0;
         cy    <= 1'b0;
         res_q <= '0;
         val_q <= 1'b0;
      end else begin
         val_q <= 1'b0;
         case (st)
            S_IDLE: begin
               if (start) begin
                  st  <= S_MUL;
                  cyc <= '0;
                  ph  <= '0;
                  dkq <= explen_i;
                  dsh <= exp_i;
                  nq  <= mod_i;
                  kq  <= rr_i;
                  cq  <= base_i;
               end
            end
            S_MUL: begin
               if (cyc == CYC_LAST) begin
                  cyc <= '0;
                  ph  <= ph + PH_W'(1);
                  if (is_pre) begin
                     p1 <= sq_s1;
                     p2 <= sq_s2;
                     r1 <= ml_s1;
                     r2 <= ml_s2;
                  end else if (is_post) begin
                     r1  <= ml_s1;
                     r2  <= ml_s2;
                     acc <= '0;
                     cy  <= 1'b0;
                     st  <= S_ADD;
                  end else begin
                     p1  <= sq_s1;
                     p2  <= sq_s2;
                     dsh <= dsh >> 1;
                     if (dsh[0]) begin
                        r1 <= ml_s1;
                        r2 <= ml_s2;
                     end
                  end
               end else begin
                  cyc <= cyc + CW'(1);
               end
            end
            S_ADD: begin
               cyc <= cyc + CW'(1);
               if (cyc < CYC_SUB) begin
                  acc <= {sb, acc[W-1:1]};
                  cy  <= cy_nxt;
                  r1  <= r1 >> 1;
                  r2  <= r2 >> 1;
               end else if (cyc == CYC_SUB) begin
                  if (acc >= nx) acc <= acc - nx;
               end else begin
                  res_q <= acc[N_W-1:0];
                  val_q <= 1'b1;
                  st    <= S_IDLE;
                  cyc   <= '0;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign busy_o   = (st != S_IDLE);
   assign valid_o  = val_q;
   assign result_o = res_q;
endmodule

// File: rtl/mexp_chk.sv
module mexp_chk #(
   parameter  int N_W  = 12,
   parameter  int E_W  = 8,
   localparam int DK_W = $clog2(E_W + 1)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic            busy,
   input logic            valid,
   input logic [N_W-1:0]  result,
   input logic [N_W-1:0]  n_q,
   input logic [DK_W-1:0] dk_q
);
   localparam int PHASE = N_W + 4;

   int run_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                run_cnt <= 0;
      else if (start && !busy)   run_cnt <= 0;
      else if (busy)             run_cnt <= run_cnt + 1;
   end

   p_result_reduced_r1: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (result < n_q));

   p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);

   p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (run_cnt == PHASE * (int'(dk_q) + 3)));

   p_idle_on_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> !busy);

   p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy) |=> ($stable(n_q) && $stable(dk_q)));
endmodule

bind mexp_top mexp_chk #(.N_W(N_W), .E_W(E_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy_o), .valid(valid_o),
   .result(result_o), .n_q(nq), .dk_q(dkq)
);

// File: tb/mexp_top_tb.sv
`timescale 1ns/1ps
module mexp_top_tb;
   localparam int N_W  = 12;
   localparam int E_W  = 8;
   localparam int DK_W = $clog2(E_W + 1);
   localparam int IT   = N_W + 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [N_W-1:0]  base_i = '0, mod_i = '0, rr_i = '0;
   logic [E_W-1:0]  exp_i = '0;
   logic [DK_W-1:0] explen_i = '0;
   logic            busy_o, valid_o;
   logic [N_W-1:0]  result_o;

   int vectors = 0;
   int fails = 0;
   bit live = 1'b0;

   // reference model state
   bit      m_busy = 1'b0, m_valid = 1'b0;
   longint  m_res = 0, m_pend = 0;
   int      m_cnt = 0;

   always #4 clk = ~clk;

   mexp_top #(.N_W(N_W), .E_W(E_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .base_i(base_i), .mod_i(mod_i),
      .rr_i(rr_i), .exp_i(exp_i), .explen_i(explen_i),
      .busy_o(busy_o), .valid_o(valid_o), .result_o(result_o)
   );

   function automatic longint rr_of(longint n);
      longint v = 1;
      for (int i = 0; i < 2 * IT; i++) v = (v * 2) % n;
      return v;
   endfunction

   function automatic longint pow_ref(longint c, longint d, int dk, longint n);
      longint r = 1 % n;
      longint b = c % n;
      for (int i = 0; i < dk; i++) begin
         if (d[i]) r = (r * b) % n;
         b = (b * b) % n;
      end
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy <= 1'b0; m_valid <= 1'b0; m_res <= 0; m_cnt <= 0;
      end else begin
         m_valid <= 1'b0;
         if (!m_busy && start) begin
            m_busy <= 1'b1;
            m_cnt  <= (IT + 2) * (int'(explen_i) + 3);
            m_pend <= pow_ref(longint'(base_i), longint'(exp_i), int'(explen_i), longint'(mod_i));
         end else if (m_busy) begin
            m_cnt <= m_cnt - 1;
            if (m_cnt == 1) begin
               m_busy  <= 1'b0;
               m_valid <= 1'b1;
               m_res   <= m_pend;
            end
         end
      end
      live <= 1'b1;
   end

   always @(negedge clk) begin
      if (live) begin
         vectors++;
         if (busy_o !== m_busy) begin
            fails++;
            $display("FAIL R6 busy_o: actual %0b expected %0b at %0t", busy_o, m_busy, $time);
         end
         if (valid_o !== m_valid) begin
            fails++;
            $display("FAIL R5 valid_o: actual %0b expected %0b at %0t", valid_o, m_valid, $time);
         end
         if (longint'(result_o) !== m_res) begin
            fails++;
            $display("FAIL R1 result_o: actual %0d expected %0d at %0t", result_o, m_res, $time);
         end
      end
   end

   task automatic check_val(string tag, longint act, longint exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic launch(longint c, longint d, int dk, longint n);
      @(negedge clk);
      base_i   = N_W'(c);
      mod_i    = N_W'(n);
      rr_i     = N_W'(rr_of(n));
      exp_i    = E_W'(d);
      explen_i = DK_W'(dk);
      start    = 1'b1;
      @(negedge clk);
      start    = 1'b0;
   endtask

   task automatic wait_valid();
      while (valid_o !== 1'b1) @(negedge clk);
   endtask

   task automatic run_case(string tag, longint c, longint d, int dk, longint n, longint exp);
      launch(c, d, dk, n);
      wait_valid();
      check_val(tag, longint'(result_o), exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL R5 watchdog: actual no completion expected completion within 200000 cycles");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R8: reset state
      check_val("R8 busy after reset", longint'(busy_o), 0);
      check_val("R8 valid after reset", longint'(valid_o), 0);
      check_val("R8 result after reset", longint'(result_o), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      run_case("R1 basic 7^13 mod 101", 7, 13, 4, 101, pow_ref(7, 13, 4, 101));
      run_case("R1 full length", 1234, 8'hB7, 8, 4093, pow_ref(1234, 8'hB7, 8, 4093));
      run_case("R3 length zero", 55, 8'hFF, 0, 97, 1);
      run_case("R3 exponent zero", 55, 0, 6, 97, 1);
      run_case("R1 exponent one", 88, 1, 1, 97, 88);
      run_case("R4 zero base", 0, 8'h2D, 7, 3001, 0);
      run_case("R2 upper bits ignored", 321, 8'hF5, 4, 2999, pow_ref(321, 5, 3, 2999));
      run_case("R1 modulus three", 2, 8'hFF, 8, 3, pow_ref(2, 255, 8, 3));
      run_case("R1 base n-1", 4094, 8'h03, 2, 4095, pow_ref(4094, 3, 2, 4095));

      // R7: new start with other operands while busy is ignored
      launch(17, 8'h5A, 7, 1009);
      repeat (20) @(negedge clk);
      base_i = 3; mod_i = 11; rr_i = N_W'(rr_of(11)); exp_i = 1; explen_i = 1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check_val("R7 still busy", longint'(busy_o), 1);
      wait_valid();
      check_val("R7 first run result kept", longint'(result_o), pow_ref(17, 8'h5A, 7, 1009));
      @(negedge clk);
      check_val("R8 result held", longint'(result_o), pow_ref(17, 8'h5A, 7, 1009));

      for (int t = 0; t < 40; t++) begin
         longint n, c, d;
         int dk;
         n  = longint'((($urandom % ((1 << N_W) - 4)) + 3) | 1);
         c  = longint'($urandom) % n;
         d  = longint'($urandom % (1 << E_W));
         dk = int'($urandom % (E_W + 1));
         run_case("R1 random", c, d, dk, n, pow_ref(c, d, dk, n));
      end

      repeat (4) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule